// File: doc/BRIEF.md
# External Memory Bus Master

This block connects a 16-bit processor core to external memory. It takes one internal request at a time: a data read, a data write or an instruction fetch. It runs that request as one or more cycles on an external bus with a 20-bit address. The bus has an active-low chip select, an output enable, a write strobe, and two byte-lane strobes, one for each half of the data bus.

A static configuration input sets the external data bus to 16 bits or 8 bits. On an 8-bit bus, a 16-bit data access becomes two byte cycles. An instruction fetch runs as a burst of 2 to 16 bytes. The burst steps only the low address bits, so it never leaves its aligned 16-byte block.

Each bus cycle has three phases:
- one address-setup cycle;
- a strobe phase of `STROBE_CYC` cycles, which the WAIT input can lengthen;
- one hold cycle.

The requester raises `reqValid` and holds its inputs steady until `reqAck` pulses.

Top module: `xbus_master`

## Requirements
- R1: While reset is active and after it is released with no request, every bus strobe is inactive (all high), the write drivers are disabled, and `reqAck` and `fetchBeat` are low.
- R2: On a 16-bit bus (`busWide`=1), a word access or fetch asserts both lane strobes. A byte access asserts only `busBlN` when address bit 0 is 0, and only `busBhN` when address bit 0 is 1.
- R3: On an 8-bit bus (`busWide`=0), `busBlN` goes low in every bus cycle, whatever the address, and `busBhN` never goes low.
- R4: On an 8-bit bus, a word access (`reqWord`=1) runs as two byte cycles. The first cycle uses the even request address and carries the low byte. The second uses the address plus one and carries the high byte. `reqAck` pulses once, after the second cycle. A read returns {second byte, first byte}.
- R5: A fetch (`reqKind`=2) of `reqLen` bytes is clamped to the range 2..16. It runs ceil(len/2) word cycles on a 16-bit bus and len byte cycles on an 8-bit bus. `fetchBeat` pulses in the hold cycle of each beat, with that beat's data on `rspData`.
- R6: Between fetch beats, address bits [3:1] advance by one on a 16-bit bus and bits [3:0] advance by one on an 8-bit bus. The advance wraps to zero inside the 16-byte block, and bits [19:4] stay fixed.
- R7: Each bus cycle is one setup cycle, then `STROBE_CYC` strobe cycles, then one hold cycle. `reqAck` is high for exactly the final hold cycle.
- R8: A high `busWait` sampled at a rising edge during the strobe phase keeps the strobes active for one more cycle.
- R9: The address is unchanged from the cycle before chip select falls to the cycle in which it falls.
- R10: Address bits [19:1] are unchanged in the cycle in which chip select returns high.
- R11: `busDoutEn` is high only in write requests. It is high only when output enable is inactive both in that cycle and in the previous one. A 16-bit write drives the whole word. A byte write drives the byte, taken from bits [7:0] or, for the second half of a split write, bits [15:8], on both lanes.
- R12: A read ends with `rspData` valid during the `reqAck` cycle. Byte reads are zero-extended: bits [15:8] of the bus on a 16-bit bus at an odd address, bits [7:0] otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWide | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| reqValid | input | 1 | Request present; held until acknowledge |
| reqKind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| reqWord | input | 1 | 1 = 16-bit data access, 0 = byte |
| reqAddr | input | 20 | Request byte address |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| reqLen | input | 5 | Fetch burst length in bytes |
| reqAck | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Read or fetch data |
| fetchBeat | output | 1 | Pulses once per fetched beat |
| busAddr | output | 20 | External address |
| busCsN | output | 1 | Chip select, active low |
| busOeN | output | 1 | Output enable, active low |
| busWeN | output | 1 | Write strobe, active low |
| busBlN | output | 1 | Low-lane byte strobe, active low |
| busBhN | output | 1 | High-lane byte strobe, active low |
| busDout | output | 16 | Write data to the bus |
| busDoutEn | output | 1 | Write-data driver enable |
| busDin | input | 16 | Read data from the bus |
| busWait | input | 1 | Stretches the strobe phase while high |

## Verification
A single-beat request is acknowledged on the (`STROBE_CYC`+2)th rising edge after the edge that accepts it. A request of B beats with W wait samples is acknowledged on edge B·(`STROBE_CYC`+2)+W. The bench counts rising edges from acceptance and compares the count with this figure.

Per-beat addresses, lane strobes and write data are recorded at the falling edge of the first strobe cycle. Fetch data is recorded at the falling edge of each `fetchBeat` cycle. `rspData` is compared one edge after the acknowledge, while it still holds its value. The setup, hold and driver-enable rules are checked on every falling edge against the values from the previous falling edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch request address and write data
    logic step;    // advance address to next beat
    logic cap;     // capture read data this cycle
    logic hiBeat;  // second half of a split word access
    logic strobe;  // strobe phase active
    logic rd;      // read or fetch transfer
    logic wr;      // write transfer in progress
    logic word;    // full-width lane usage
  } dpCtl_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int STROBE_CYC = 2,
  parameter int LEN_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWide,
  input  logic             busWait,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             reqWord,
  input  logic [LEN_W-1:0] reqLen,
  output dpCtl_t           ctl,
  output logic             reqAck,
  output logic             fetchBeat
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  phase_e           phase;
  kind_e            kindQ;
  logic             wordQ;
  logic             hiBeatQ;
  logic [LEN_W-1:0] beatsLeft;
  logic [CNT_W-1:0] cnt;

  logic [LEN_W-1:0] lenC;
  logic [LEN_W-1:0] beatsReq;
  logic             strobeDone;

  always_comb begin
    if (reqLen < LEN_W'(2))       lenC = LEN_W'(2);
    else if (reqLen > LEN_W'(16)) lenC = LEN_W'(16);
    else                          lenC = reqLen;
    if (kind_e'(reqKind) == KIND_FETCH)
      beatsReq = busWide ? LEN_W'((lenC + LEN_W'(1)) >> 1) : lenC;
    else
      beatsReq = (!busWide && reqWord) ? LEN_W'(2) : LEN_W'(1);
  end

  assign strobeDone = (phase == PH_STROBE) && !busWait && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      kindQ     <= KIND_READ;
      wordQ     <= 1'b0;
      hiBeatQ   <= 1'b0;
      beatsLeft <= '0;
      cnt       <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (reqValid) begin
          kindQ     <= kind_e'(reqKind);
          wordQ     <= reqWord;
          hiBeatQ   <= 1'b0;
          beatsLeft <= beatsReq - LEN_W'(1);
          phase     <= PH_SETUP;
        end
        PH_SETUP: begin
          cnt   <= '0;
          phase <= PH_STROBE;
        end
        PH_STROBE: if (!busWait) begin
          if (cnt == CNT_LAST) phase <= PH_HOLD;
          else                 cnt   <= cnt + CNT_W'(1);
        end
        default: begin
          if (beatsLeft != '0) begin
            beatsLeft <= beatsLeft - LEN_W'(1);
            hiBeatQ   <= (kindQ != KIND_FETCH);
            phase     <= PH_SETUP;
          end else begin
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.load   = (phase == PH_IDLE) && reqValid;
    ctl.step   = (phase == PH_HOLD) && (beatsLeft != '0);
    ctl.cap    = strobeDone && (kindQ != KIND_WRITE);
    ctl.hiBeat = hiBeatQ;
    ctl.strobe = (phase == PH_STROBE);
    ctl.rd     = (kindQ != KIND_WRITE);
    ctl.wr     = (kindQ == KIND_WRITE) && (phase != PH_IDLE);
    ctl.word   = wordQ || (kindQ == KIND_FETCH);
  end

  assign reqAck    = (phase == PH_HOLD) && (beatsLeft == '0);
  assign fetchBeat = (phase == PH_HOLD) && (kindQ == KIND_FETCH);

  // R8
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && busWait) |=> (phase == PH_STROBE));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R7
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.strobe) |-> (phase == PH_HOLD));

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busCsN,
  output logic              busOeN,
  output logic              busWeN,
  output logic              busBlN,
  output logic              busBhN,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  output logic [DATA_W-1:0] rspData
);
  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [LANE_W-1:0] wrByte;
  logic [LANE_W-1:0] rdByte;

  // burst step stays inside the aligned 16-byte block
  always_comb begin
    addrNext = addrQ;
    if (busWide) addrNext[3:1] = addrQ[3:1] + 3'd1;
    else         addrNext[3:0] = addrQ[3:0] + 4'd1;
  end

  assign rdByte = (busWide && addrQ[0]) ? busDin[DATA_W-1:LANE_W] : busDin[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end else if (ctl.step) begin
        addrQ <= addrNext;
      end
      if (ctl.cap) begin
        if (busWide && ctl.word)     rdataQ <= busDin;
        else if (!busWide && ctl.hiBeat)
          rdataQ[DATA_W-1:LANE_W] <= busDin[LANE_W-1:0];
        else                         rdataQ <= {{LANE_W{1'b0}}, rdByte};
      end
    end
  end

  assign wrByte = (!busWide && ctl.hiBeat) ? wdataQ[DATA_W-1:LANE_W] : wdataQ[LANE_W-1:0];

  always_comb begin
    busAddr   = addrQ;
    busCsN    = !ctl.strobe;
    busOeN    = !(ctl.strobe && ctl.rd);
    busWeN    = !(ctl.strobe && ctl.wr);
    busBlN    = !(ctl.strobe && (!busWide || ctl.word || !addrQ[0]));
    busBhN    = !(ctl.strobe && busWide && (ctl.word || addrQ[0]));
    busDout   = (busWide && ctl.word) ? wdataQ : {wrByte, wrByte};
    busDoutEn = ctl.wr;
    rspData   = rdataQ;
  end

  // R9
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCsN) |-> $stable(busAddr));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCsN) |-> $stable(busAddr[ADDR_W-1:1]));

  // R3
  narrow_bh_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWide |-> busBhN);

  // R11
  drive_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDoutEn |-> (busOeN && $past(busOeN)));

  // R2
  wide_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && busWide) |-> !(busBlN && busBhN));

endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 5,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqAck,
  output logic [DATA_W-1:0] rspData,
  output logic              fetchBeat,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busCsN,
  output logic              busOeN,
  output logic              busWeN,
  output logic              busBlN,
  output logic              busBhN,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busWait
);
  dpCtl_t ctl;

  xbus_ctrl #(.STROBE_CYC(STROBE_CYC), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWide(busWide), .busWait(busWait),
    .reqValid(reqValid), .reqKind(reqKind), .reqWord(reqWord), .reqLen(reqLen),
    .ctl(ctl), .reqAck(reqAck), .fetchBeat(fetchBeat)
  );

  xbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .busWide(busWide), .ctl(ctl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDin(busDin),
    .busAddr(busAddr), .busCsN(busCsN), .busOeN(busOeN), .busWeN(busWeN),
    .busBlN(busBlN), .busBhN(busBhN), .busDout(busDout), .busDoutEn(busDoutEn),
    .rspData(rspData)
  );

endmodule

// File: tb/sim_xbus_master.sv
module sim_xbus_master;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWide = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic        reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [4:0]  reqLen = 5'd2;
  logic        reqAck, fetchBeat;
  logic [15:0] rspData;
  logic [19:0] busAddr;
  logic        busCsN, busOeN, busWeN, busBlN, busBhN, busDoutEn;
  logic [15:0] busDout, busDin;
  logic        busWait = 1'b0;

  always #5 clk = ~clk;

  // memory model: low lane = addr[7:0], high lane = ~addr[7:0]
  assign busDin = {~busAddr[7:0], busAddr[7:0]};

  xbus_master #(.STROBE_CYC(S)) u0 (
    .clk(clk), .rstN(rstN), .busWide(busWide), .reqValid(reqValid),
    .reqKind(reqKind), .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqLen(reqLen), .reqAck(reqAck), .rspData(rspData), .fetchBeat(fetchBeat),
    .busAddr(busAddr), .busCsN(busCsN), .busOeN(busOeN), .busWeN(busWeN),
    .busBlN(busBlN), .busBhN(busBhN), .busDout(busDout), .busDoutEn(busDoutEn),
    .busDin(busDin), .busWait(busWait)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, sampled at falling edges
  logic [19:0] bAddr [16];
  logic        bBl [16];
  logic        bBh [16];
  logic        bWe [16];
  logic        bOe [16];
  logic        bEn [16];
  logic [15:0] bDout [16];
  logic [15:0] fData [16];
  int          nBeat = 0, nFetch = 0, waitBudget = 0, protoErr = 0;
  logic        prevCs = 1'b1, prevOe = 1'b1;
  logic [19:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !busCsN) begin
        if (busAddr !== prevAddr) protoErr++;  // R9
        if (nBeat < 16) begin
          bAddr[nBeat] = busAddr; bBl[nBeat] = busBlN; bBh[nBeat] = busBhN;
          bWe[nBeat] = busWeN; bOe[nBeat] = busOeN; bEn[nBeat] = busDoutEn;
          bDout[nBeat] = busDout;
        end
        nBeat++;
      end
      if (!prevCs && busCsN && (busAddr[19:1] !== prevAddr[19:1])) protoErr++;  // R10
      if (busDoutEn && (!busOeN || !prevOe)) protoErr++;  // R11
      if (!busWide && !busBhN) protoErr++;  // R3
      if (fetchBeat) begin
        if (nFetch < 16) fData[nFetch] = rspData;
        nFetch++;
      end
      if (!busCsN && waitBudget > 0) begin
        busWait = 1'b1;
        waitBudget--;
      end else begin
        busWait = 1'b0;
      end
    end
    prevCs = busCsN;
    prevOe = busOeN;
    prevAddr = busAddr;
  end

  task automatic runReq(input logic wide, input logic [1:0] kind, input logic word,
                        input logic [19:0] addr, input logic [15:0] wd,
                        input logic [4:0] len, input int waits, output int lat);
    @(negedge clk);
    busWide = wide; reqKind = kind; reqWord = word; reqAddr = addr;
    reqWdata = wd; reqLen = len; reqValid = 1'b1;
    nBeat = 0; nFetch = 0; waitBudget = waits;
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (reqAck) break;
    end
    reqValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    chk("R1 csN", busCsN, 1); chk("R1 oeN", busOeN, 1); chk("R1 weN", busWeN, 1);
    chk("R1 blN", busBlN, 1); chk("R1 bhN", busBhN, 1);
    chk("R1 doutEn", busDoutEn, 0); chk("R1 ack", reqAck, 0); chk("R1 fetchBeat", fetchBeat, 0);
  endtask

  task automatic testWideWrite();
    int lat;
    runReq(1'b1, 2'd1, 1'b0, 20'h00102, 16'h005A, 5'd2, 0, lat);
    chk("R7 latency single", lat, S + 2);
    chk("R2 even byte blN", bBl[0], 0); chk("R2 even byte bhN", bBh[0], 1);
    chk("R11 weN low", bWe[0], 0); chk("R11 oeN high", bOe[0], 1);
    chk("R11 doutEn", bEn[0], 1); chk("R11 dout lo", bDout[0][7:0], 8'h5A);
    runReq(1'b1, 2'd1, 1'b0, 20'h00103, 16'h00C3, 5'd2, 0, lat);
    chk("R2 odd byte blN", bBl[0], 1); chk("R2 odd byte bhN", bBh[0], 0);
    chk("R11 dout hi", bDout[0][15:8], 8'hC3);
    runReq(1'b1, 2'd1, 1'b1, 20'h00104, 16'h1234, 5'd2, 0, lat);
    chk("R2 word blN", bBl[0], 0); chk("R2 word bhN", bBh[0], 0);
    chk("R11 dout word", bDout[0], 16'h1234);
  endtask

  task automatic testWideRead();
    int lat;
    runReq(1'b1, 2'd0, 1'b1, 20'h2A0F0, 16'h0, 5'd2, 0, lat);
    chk("R12 word read", rspData, 16'h0FF0);
    chk("R11 no drive on read", bEn[0], 0);
    chk("R2 read both lanes", {bBl[0], bBh[0]}, 2'b00);
    runReq(1'b1, 2'd0, 1'b0, 20'h2A0F1, 16'h0, 5'd2, 0, lat);
    chk("R12 odd byte read", rspData, 16'h000E);
    runReq(1'b1, 2'd0, 1'b0, 20'h2A0F2, 16'h0, 5'd2, 0, lat);
    chk("R12 even byte read", rspData, 16'h00F2);
  endtask

  task automatic testNarrow();
    int lat;
    runReq(1'b0, 2'd0, 1'b1, 20'h3C126, 16'h0, 5'd2, 0, lat);
    chk("R4 beats", nBeat, 2);
    chk("R4 latency", lat, 2 * (S + 2));
    chk("R4 addr0", bAddr[0], 20'h3C126); chk("R4 addr1", bAddr[1], 20'h3C127);
    chk("R4 read assembled", rspData, 16'h2726);
    chk("R3 lanes beat0", {bBl[0], bBh[0]}, 2'b01);
    chk("R3 lanes beat1", {bBl[1], bBh[1]}, 2'b01);
    runReq(1'b0, 2'd1, 1'b0, 20'h3C127, 16'h0099, 5'd2, 0, lat);
    chk("R3 odd byte blN", bBl[0], 0); chk("R3 odd byte bhN", bBh[0], 1);
    chk("R11 narrow dout", bDout[0][7:0], 8'h99);
    runReq(1'b0, 2'd1, 1'b1, 20'h00010, 16'hBEEF, 5'd2, 0, lat);
    chk("R4 write beats", nBeat, 2);
    chk("R4 write low first", bDout[0][7:0], 8'hEF);
    chk("R4 write high second", bDout[1][7:0], 8'hBE);
  endtask

  task automatic testFetch();
    int lat;
    runReq(1'b1, 2'd2, 1'b0, 20'h1234C, 16'h0, 5'd8, 0, lat);
    chk("R5 wide beats", nFetch, 4);
    chk("R7 burst latency", lat, 4 * (S + 2));
    chk("R6 wide addr1", bAddr[1], 20'h1234E);
    chk("R6 wide wrap", bAddr[2], 20'h12340);
    chk("R6 wide addr3", bAddr[3], 20'h12342);
    chk("R5 wide data", fData[2], 16'hBF40);
    chk("R2 fetch both lanes", {bBl[1], bBh[1]}, 2'b00);
    runReq(1'b0, 2'd2, 1'b0, 20'h0ABCE, 16'h0, 5'd3, 0, lat);
    chk("R5 narrow beats", nFetch, 3);
    chk("R6 narrow addr1", bAddr[1], 20'h0ABCF);
    chk("R6 narrow wrap", bAddr[2], 20'h0ABC0);
    chk("R5 narrow data", fData[1], 16'h00CF);
    runReq(1'b1, 2'd2, 1'b0, 20'h50000, 16'h0, 5'd16, 0, lat);
    chk("R5 max beats", nFetch, 8);
    chk("R6 last addr", bAddr[7], 20'h5000E);
    runReq(1'b1, 2'd2, 1'b0, 20'h50000, 16'h0, 5'd20, 0, lat);
    chk("R5 clamp beats", nFetch, 8);
  endtask

  task automatic testWait();
    int lat;
    runReq(1'b1, 2'd0, 1'b0, 20'h00042, 16'h0, 5'd2, 3, lat);
    chk("R8 wait latency", lat, S + 2 + 3);
    chk("R8 data after wait", rspData, 16'h0042);
    runReq(1'b0, 2'd0, 1'b1, 20'h00042, 16'h0, 5'd2, 2, lat);
    chk("R8 split wait latency", lat, 2 * (S + 2) + 2);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWideWrite();
    testWideRead();
    testNarrow();
    testFetch();
    testWait();
    chk("R9 R10 R11 bus protocol", protoErr, 0);
    summary();
    $finish;
  end

endmodule